// File: doc/BRIEF.md
# Single-Cycle Three-Format Integer Core

This block is a 32-bit processor that finishes one instruction per clock. Each cycle it presents the program counter on a byte-addressed fetch port and takes the instruction word back in the same cycle. It then decodes the register, immediate or jump format, reads two operands from a 32-entry register file and performs one arithmetic, compare, logical, memory, branch or jump operation. The result is written back at the clock edge, and the counter moves to the sequential or redirected address.

Data memory is a single port with a byte address, a word of write data, per-lane byte enables (lane 0 is the least significant byte, little-endian) and a write strobe. Read data is expected in the same cycle. Register 0 is constant zero. A jump that links stores its return address in register 31.

When the core meets an instruction it does not know, or a signed add or subtract overflows, it raises a trap output and freezes. The trap stays set until reset. No register or memory write takes place from the trapping instruction onward. Reset is asynchronous active-low at the pin and is released to the core through a two-stage synchroniser.

Top module: `tri_core`

## Requirements
- R1: While reset is held, and after it is released, the fetch address starts at 0 and the trap output is 0, including after an earlier trap. The write strobe stays low while reset is held.
- R2: Register 0 reads as zero. Writes to it, from either R-format `add` (rd=0) or `addi` (rt=0), have no effect.
- R3: Signed add (opcode 0, funct 32), subtract (funct 34) and add-immediate (opcode 8) raise the trap on two's-complement overflow. The destination is then left unwritten and the counter holds at the overflowing instruction.
- R4: Encoding: opcode is bits 31:26; rs is 25:21; rt is 20:16; rd is 15:11; shamt is 10:6; funct is 5:0; the immediate is 15:0; the jump index is 25:0. `add`/`sub` write rs±rt to rd. `addi` adds the sign-extended immediate. `ori` (13) ORs the zero-extended immediate. `lui` (15) places the immediate in bits 31:16 and clears bits 15:0.
- R5: `slt` (funct 42) and `slti` (opcode 10) write 1 when rs is less than the second operand as signed numbers, and 0 otherwise. The immediate is sign-extended.
- R6: `lw` (35) and `sw` (43) access the word at rs plus the sign-extended immediate.
- R7: `lb` (32) returns the addressed byte, sign-extended. `sb` (40) writes only the low byte of rt into the addressed lane and leaves the other three bytes of the word unchanged.
- R8: `beq` (4) and `bne` (5) go to PC+4+4×sext(imm) when taken, with negative displacements allowed, and to PC+4 otherwise.
- R9: `j` (2) and `jal` (3) go to {PC+4[31:28], index, 2'b00}. `jal` also writes PC+4 to register 31.
- R10: `jr` (opcode 0, funct 8) continues at the address held in rs.
- R11: An unknown opcode, or an R-format word with an unknown funct or a non-zero shamt, raises a sticky trap. The counter then holds and nothing further is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word for imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data; for byte stores the byte is repeated in every lane |
| dmem_be | output | 4 | Byte-lane enables for a store |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Word at the aligned dmem_addr, same cycle |
| trap | output | 1 | Sticky halt indication |

## Verification
The assertions assume that every jump-register target and every word access is 4-byte aligned, since the core does not check alignment. They also assume that both memories return their data combinationally in the cycle the address is presented. The bench's memory models answer in the same cycle, and its programs build every address from aligned constants. The programs also keep code within a 64-word window and end in a jump to self, so the counter never leaves known code and never becomes misaligned.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN     = 32;
  localparam int NREG     = 32;
  localparam int REG_AW   = $clog2(NREG);
  localparam int NLANE    = XLEN / 8;
  localparam int LANE_AW  = $clog2(NLANE);
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int OPC_W    = 6;
  localparam int FN_W     = 6;
  localparam int SH_W     = 5;
  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(NREG - 1);

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_J    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL  = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LB   = 6'd32;
  localparam logic [OPC_W-1:0] OPC_LW   = 6'd35;
  localparam logic [OPC_W-1:0] OPC_SB   = 6'd40;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'd43;

  localparam logic [FN_W-1:0] FN_JR  = 6'd8;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_HIGH
  } alu_op_e;

  typedef enum logic [1:0] {
    NPC_SEQ, NPC_BRANCH, NPC_JUMP, NPC_REG
  } npc_sel_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_WORD, WB_BYTE, WB_LINK
  } wb_sel_e;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     use_imm;
    logic     zext_imm;
    logic     reg_write;
    logic     dst_rd;
    logic     dst_link;
    wb_sel_e  wb_sel;
    logic     mem_write;
    logic     mem_byte;
    logic     is_branch;
    logic     branch_ne;
    npc_sel_e npc_sel;
    logic     ovf_check;
    logic     illegal;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic [SH_W-1:0]  shamt,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.alu_op    = ALU_ADD;
    ctrl.wb_sel    = WB_ALU;
    ctrl.npc_sel   = NPC_SEQ;
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        if (shamt != '0) begin
          ctrl.illegal = 1'b1;
        end else begin
          unique case (funct)
            FN_ADD: begin
              ctrl.reg_write = 1'b1;
              ctrl.ovf_check = 1'b1;
            end
            FN_SUB: begin
              ctrl.alu_op    = ALU_SUB;
              ctrl.reg_write = 1'b1;
              ctrl.ovf_check = 1'b1;
            end
            FN_SLT: begin
              ctrl.alu_op    = ALU_SLT;
              ctrl.reg_write = 1'b1;
            end
            FN_JR: begin
              ctrl.npc_sel = NPC_REG;
            end
            default: ctrl.illegal = 1'b1;
          endcase
        end
      end
      OPC_ADDI: begin
        ctrl.use_imm   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.ovf_check = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.alu_op    = ALU_SLT;
        ctrl.use_imm   = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OPC_ORI: begin
        ctrl.alu_op    = ALU_OR;
        ctrl.use_imm   = 1'b1;
        ctrl.zext_imm  = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OPC_LUI: begin
        ctrl.alu_op    = ALU_HIGH;
        ctrl.use_imm   = 1'b1;
        ctrl.zext_imm  = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OPC_LW: begin
        ctrl.use_imm   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.wb_sel    = WB_WORD;
      end
      OPC_LB: begin
        ctrl.use_imm   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.wb_sel    = WB_BYTE;
      end
      OPC_SW: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_SB: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.mem_byte  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.npc_sel   = NPC_BRANCH;
      end
      OPC_BNE: begin
        ctrl.is_branch = 1'b1;
        ctrl.branch_ne = 1'b1;
        ctrl.npc_sel   = NPC_BRANCH;
      end
      OPC_J: begin
        ctrl.npc_sel = NPC_JUMP;
      end
      OPC_JAL: begin
        ctrl.npc_sel   = NPC_JUMP;
        ctrl.reg_write = 1'b1;
        ctrl.dst_link  = 1'b1;
        ctrl.wb_sel    = WB_LINK;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int DW = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs [1:N-1];
  logic [N-1:0]  wsel;

  always_comb begin
    wsel = '0;
    for (int i = 1; i < N; i++) begin
      wsel[i] = we && (waddr == AW'(i));
    end
  end

  for (genvar gi = 1; gi < N; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wsel[gi]) begin
        regs[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 1; i < N; i++) begin
      if (raddr_a == AW'(i)) rdata_a = regs[i];
      if (raddr_b == AW'(i)) rdata_b = regs[i];
    end
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          ovf
);

  localparam int HALF = DW / 2;

  logic [DW-1:0] sum;
  logic [DW-1:0] diff;

  always_comb begin
    sum  = a + b;
    diff = a - b;
    ovf  = 1'b0;
    unique case (op)
      ALU_ADD: begin
        y   = sum;
        ovf = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
      end
      ALU_SUB: begin
        y   = diff;
        ovf = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
      end
      ALU_SLT:  y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_OR:   y = a | b;
      ALU_HIGH: y = {b[HALF-1:0], {HALF{1'b0}}};
      default:  y = sum;
    endcase
  end

endmodule

// File: rtl/core_nextpc.sv
module core_nextpc
  import core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     pc,
  input  npc_sel_e          sel,
  input  logic              branch_ne,
  input  logic [DW-1:0]     rs_val,
  input  logic [DW-1:0]     rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  output logic [DW-1:0]     pc_plus4,
  output logic [DW-1:0]     npc
);

  localparam int REGION_LO = JIDX_W + 2;

  logic [DW-1:0] br_off;
  logic          taken;

  always_comb begin
    pc_plus4 = pc + DW'(4);
    br_off   = {{(DW-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    taken    = (rs_val == rt_val) ^ branch_ne;
    unique case (sel)
      NPC_BRANCH: npc = taken ? (pc_plus4 + br_off) : pc_plus4;
      NPC_JUMP:   npc = {pc_plus4[DW-1:REGION_LO], jidx, 2'b00};
      NPC_REG:    npc = rs_val;
      default:    npc = pc_plus4;
    endcase
  end

endmodule

// File: rtl/tri_core.sv
module tri_core
  import core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [XLEN-1:0]  imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic [NLANE-1:0] dmem_be,
  output logic             dmem_we,
  input  logic [XLEN-1:0]  dmem_rdata,
  output logic             trap
);

  // reset synchroniser: asynchronous assertion, clocked release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // architectural state
  logic [XLEN-1:0] pc_q, pc_d;
  logic            trap_q, trap_d;
  logic            pc_en;

  // instruction fields
  logic [OPC_W-1:0]  opcode;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx;
  logic [SH_W-1:0]   shamt;
  logic [FN_W-1:0]   funct;
  logic [IMM_W-1:0]  imm;
  logic [JIDX_W-1:0] jidx;

  assign opcode = imem_rdata[31:26];
  assign rs_idx = imem_rdata[25:21];
  assign rt_idx = imem_rdata[20:16];
  assign rd_idx = imem_rdata[15:11];
  assign shamt  = imem_rdata[10:6];
  assign funct  = imem_rdata[5:0];
  assign imm    = imem_rdata[IMM_W-1:0];
  assign jidx   = imem_rdata[JIDX_W-1:0];

  ctrl_t ctrl;

  core_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .shamt  (shamt),
    .ctrl   (ctrl)
  );

  // register file
  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  logic [XLEN-1:0]   rs_val, rt_val;

  core_regfile #(.DW(XLEN), .N(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  // execute
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_ovf;

  always_comb begin
    if (ctrl.zext_imm) imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
    else               imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    alu_b = ctrl.use_imm ? imm_ext : rt_val;
  end

  core_alu #(.DW(XLEN)) u_alu (
    .op  (ctrl.alu_op),
    .a   (rs_val),
    .b   (alu_b),
    .y   (alu_y),
    .ovf (alu_ovf)
  );

  // next program counter
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] npc;

  core_nextpc #(.DW(XLEN)) u_npc (
    .pc        (pc_q),
    .sel       (ctrl.npc_sel),
    .branch_ne (ctrl.branch_ne),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .imm       (imm),
    .jidx      (jidx),
    .pc_plus4  (pc_plus4),
    .npc       (npc)
  );

  // commit control
  logic run;
  logic trap_now;
  logic commit;
  logic link_op;

  assign run      = rst_sync_n && !trap_q;
  assign trap_now = ctrl.illegal || (ctrl.ovf_check && alu_ovf);
  assign commit   = run && !trap_now;
  assign link_op  = ctrl.dst_link;

  // data memory lanes
  logic [LANE_AW-1:0] lane;
  logic [7:0]         lbyte;

  assign lane = alu_y[LANE_AW-1:0];

  always_comb begin
    lbyte      = dmem_rdata[lane*8 +: 8];
    dmem_addr  = alu_y;
    dmem_we    = commit && ctrl.mem_write;
    if (ctrl.mem_byte) begin
      dmem_wdata    = {NLANE{rt_val[7:0]}};
      dmem_be       = '0;
      dmem_be[lane] = 1'b1;
    end else begin
      dmem_wdata = rt_val;
      dmem_be    = '1;
    end
  end

  // write-back
  always_comb begin
    rf_we = commit && ctrl.reg_write;
    if (ctrl.dst_link)    rf_waddr = LINK_REG;
    else if (ctrl.dst_rd) rf_waddr = rd_idx;
    else                  rf_waddr = rt_idx;
    unique case (ctrl.wb_sel)
      WB_WORD: rf_wdata = dmem_rdata;
      WB_BYTE: rf_wdata = {{(XLEN-8){lbyte[7]}}, lbyte};
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  // next state
  always_comb begin
    pc_en  = commit;
    pc_d   = npc;
    trap_d = trap_q || (run && trap_now);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      trap_q <= trap_d;
    end
  end

  assign imem_addr = pc_q;
  assign trap      = trap_q;

endmodule

// File: rtl/core_checker.sv
module core_checker
  import core_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              trap,
  input logic [XLEN-1:0]   pc,
  input logic              dmem_we,
  input logic [REG_AW-1:0] rs_idx,
  input logic [XLEN-1:0]   rs_val,
  input logic              run,
  input logic              trap_now,
  input logic              link_op,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic [XLEN-1:0]   rf_wdata
);

  // R1: held in reset means counter at zero and no trap
  always @(posedge clk) begin
    if (rst_sync_n == 1'b0) begin
      p_reset_state_r1: assert (pc == '0 && trap == 1'b0)
        else $error("reset state wrong");
    end
  end

  p_r0_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_idx == '0) |-> (rs_val == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && trap_now) |=> trap);

  p_quiet_on_trap_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap |-> !dmem_we && !rf_we);

  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc[1:0] == 2'b00);

  p_link_target_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && link_op) |-> (rf_we && rf_waddr == LINK_REG && rf_wdata == pc + XLEN'(4)));

  p_trap_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap |=> trap);

  p_pc_frozen_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap |=> $stable(pc));

endmodule

bind tri_core core_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .trap       (trap),
  .pc         (pc_q),
  .dmem_we    (dmem_we),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val),
  .run        (run),
  .trap_now   (trap_now),
  .link_op    (link_op),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .rf_wdata   (rf_wdata)
);

// File: tb/tri_core_test.sv
`timescale 1ns/1ps
module tri_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;
  logic        trap;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #2.5 clk = ~clk;

  tri_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_be    (dmem_be),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .trap       (trap)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      for (int b = 0; b < 4; b++) begin
        if (dmem_be[b]) dmem[dmem_addr[7:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
      end
    end
  end

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input int op, input int idx);
    return {6'(op), 26'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // hold reset and fill both memories with defaults (self-loops, sentinels)
  task automatic start_load();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc_j(2, i);
      dmem[i] = SENT;
    end
  endtask

  task automatic release_run(input int ncyc);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  // op select: 0 add, 1 sub, 2 slt
  localparam logic [98:0] VEC [0:7] = '{
    {2'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0},
    {2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1},
    {2'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0},
    {2'd1, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 1'b1},
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0},
    {2'd2, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0},
    {2'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}
  };

  initial begin
    // R1: reset state
    start_load();
    imem[0] = enc_i(43, 0, 0, 0);
    @(negedge clk);
    chk_eq("R1 pc in reset", imem_addr, 32'd0);
    chk_eq("R1 trap in reset", {31'd0, trap}, 32'd0);
    chk_eq("R1 no store in reset", {31'd0, dmem_we}, 32'd0);

    // R3 R4 R5: table of register-register operations
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  sel;
      logic [31:0] a, b, exp;
      logic        etrap;
      int          fn;
      {sel, a, b, exp, etrap} = VEC[v];
      fn = (sel == 2'd0) ? 32 : (sel == 2'd1) ? 34 : 42;
      start_load();
      imem[0] = enc_i(15, 0, 1, int'(a[31:16]));
      imem[1] = enc_i(13, 1, 1, int'(a[15:0]));
      imem[2] = enc_i(15, 0, 2, int'(b[31:16]));
      imem[3] = enc_i(13, 2, 2, int'(b[15:0]));
      imem[4] = enc_r(1, 2, 3, fn);
      imem[5] = enc_i(43, 0, 3, 16);
      release_run(20);
      if (etrap) begin
        chk_eq($sformatf("R3 overflow trap vec%0d", v), {31'd0, trap}, 32'd1);
        chk_eq($sformatf("R3 pc held vec%0d", v), imem_addr, 32'd16);
        chk_eq($sformatf("R3 no result vec%0d", v), dmem[4], SENT);
      end else begin
        chk_eq($sformatf("R4 R5 result vec%0d", v), dmem[4], exp);
        chk_eq($sformatf("R3 no trap vec%0d", v), {31'd0, trap}, 32'd0);
      end
    end

    // R2: writes to register 0 are dropped
    start_load();
    imem[0] = enc_i(8, 0, 1, 7);
    imem[1] = enc_r(1, 1, 0, 32);
    imem[2] = enc_i(8, 0, 0, 5);
    imem[3] = enc_i(43, 0, 0, 20);
    release_run(20);
    chk_eq("R2 register 0 stays zero", dmem[5], 32'd0);

    // R4 R5: immediate forms
    start_load();
    imem[0] = enc_i(8, 0, 5, 16'hFFEC);
    imem[1] = enc_i(13, 0, 6, 16'h8001);
    imem[2] = enc_i(10, 5, 7, 16'hFFED);
    imem[3] = enc_i(10, 6, 8, 16'hFFFF);
    imem[4] = enc_i(15, 0, 9, 16'h8765);
    imem[5] = enc_i(43, 0, 5, 0);
    imem[6] = enc_i(43, 0, 6, 4);
    imem[7] = enc_i(43, 0, 7, 8);
    imem[8] = enc_i(43, 0, 8, 12);
    imem[9] = enc_i(43, 0, 9, 16);
    release_run(25);
    chk_eq("R4 addi sign-extends", dmem[0], 32'hFFFF_FFEC);
    chk_eq("R4 ori zero-extends", dmem[1], 32'h0000_8001);
    chk_eq("R5 slti less", dmem[2], 32'd1);
    chk_eq("R5 slti not less", dmem[3], 32'd0);
    chk_eq("R4 lui", dmem[4], 32'h8765_0000);

    // R6 R7: loads and stores
    start_load();
    dmem[8]  = 32'h1234_80FF;
    dmem[10] = 32'h1111_1111;
    imem[0] = enc_i(8, 0, 1, 40);
    imem[1] = enc_i(35, 1, 2, -8);
    imem[2] = enc_i(32, 1, 3, -7);
    imem[3] = enc_i(32, 1, 4, -5);
    imem[4] = enc_i(8, 0, 5, 16'h01AB);
    imem[5] = enc_i(40, 1, 5, 2);
    imem[6] = enc_i(43, 1, 2, 4);
    imem[7] = enc_i(43, 1, 3, 8);
    imem[8] = enc_i(43, 1, 4, 12);
    release_run(25);
    chk_eq("R6 lw with negative offset", dmem[11], 32'h1234_80FF);
    chk_eq("R7 lb negative byte", dmem[12], 32'hFFFF_FF80);
    chk_eq("R7 lb positive byte", dmem[13], 32'h0000_0012);
    chk_eq("R7 sb single lane", dmem[10], 32'h11AB_1111);

    // R8: branches, taken and not, forward and backward
    start_load();
    for (int i = 3; i <= 10; i++) imem[i] = enc_i(43, 0, 1, 40);
    imem[0]  = enc_i(8, 0, 1, 3);
    imem[1]  = enc_i(8, 0, 2, 3);
    imem[2]  = enc_i(4, 1, 2, 3);
    imem[6]  = enc_i(5, 1, 2, 1);
    imem[7]  = enc_i(8, 0, 3, 9);
    imem[8]  = enc_i(5, 1, 3, 2);
    imem[11] = enc_i(4, 0, 0, 2);
    imem[12] = enc_i(43, 0, 3, 44);
    imem[13] = enc_j(2, 13);
    imem[14] = enc_i(4, 0, 0, -3);
    release_run(30);
    chk_eq("R8 skipped paths wrote nothing", dmem[10], SENT);
    chk_eq("R8 backward target reached", dmem[11], 32'd9);
    chk_eq("R8 final pc", imem_addr, 32'd52);

    // R9 R10: jump-and-link then jump-register
    start_load();
    imem[0] = enc_j(3, 4);
    imem[1] = enc_j(2, 1);
    imem[4] = enc_i(43, 0, 31, 24);
    imem[5] = enc_r(31, 0, 0, 8);
    release_run(20);
    chk_eq("R9 link register holds pc+4", dmem[6], 32'd4);
    chk_eq("R10 returned through rs", imem_addr, 32'd4);

    // R11: unknown opcode
    start_load();
    imem[0] = enc_i(8, 0, 1, 1);
    imem[1] = 32'hFC00_0000;
    imem[2] = enc_i(43, 0, 1, 20);
    release_run(15);
    chk_eq("R11 trap on bad opcode", {31'd0, trap}, 32'd1);
    chk_eq("R11 pc frozen", imem_addr, 32'd4);
    repeat (10) @(negedge clk);
    chk_eq("R11 trap sticky", {31'd0, trap}, 32'd1);
    chk_eq("R11 no later store", dmem[5], SENT);

    // R1: reset clears a trap
    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1 reset clears trap", {31'd0, trap}, 32'd0);
    chk_eq("R1 reset clears pc", imem_addr, 32'd0);

    // R11: unknown funct and non-zero shamt
    start_load();
    imem[0] = enc_r(0, 0, 1, 0);
    release_run(10);
    chk_eq("R11 trap on bad funct", {31'd0, trap}, 32'd1);
    chk_eq("R11 pc at bad funct", imem_addr, 32'd0);
    start_load();
    imem[0] = enc_r(0, 0, 1, 32) | 32'h0000_0040;
    release_run(10);
    chk_eq("R11 trap on shamt", {31'd0, trap}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule